// File: doc/BRIEF.md
# Serial In-Circuit Programming Command Engine

This block is the device-side end of a two-wire synchronous programming link. The external programmer drives a serial clock and shares one data line with the device. The engine samples both lines on its own system clock, which also serves as its instruction cycle. It assembles 8-bit commands that arrive least significant bit first. For some commands it then receives or transmits a 16-bit word. It holds an address pointer and a data latch and drives the port of a word-wide program memory.

A write cycle has no fixed length. A begin-programming command raises the memory write strobe, and the strobe stays high until the last falling clock edge of the next command. That command is then executed in the same cycle. After any command or word, the engine ignores serial clock edges for a configurable number of cycles. This enforces the minimum gaps, the initialisation time after reset and the minimum write time. A code-protect input suppresses the write strobe.

Top module: `sp_prog_engine`

## Requirements
- R1: After reset, the pointer is 0x0000, `ser_oe` is low and `mem_we` is low.
- R2: Serial clock edges are ignored for INIT_CYC cycles after reset.
- R3: A command is 8 bits sampled on falling serial clock edges, least significant bit first. The codes are 0x00 clear pointer, 0x02 load data, 0x04 read data, 0x06 increment pointer, 0x08 begin programming, 0x0A load address, 0x0C read address and 0x0E end programming.
- R4: 0x0A followed by a 16-bit word, least significant bit first, sets the pointer. 0x0C returns the pointer as a 16-bit word.
- R5: 0x00 clears the pointer. 0x06 adds one to the pointer, and 0xFFFF wraps to 0x0000.
- R6: On 0x04 or 0x0C, `ser_oe` rises at the command's 8th falling edge and falls at the word's 16th falling edge. Bit k, least significant first, appears on `ser_dout` after rising edge k of the word.
- R7: 0x02 only latches a word, and memory is not written. The pointer may change before programming starts, and the write uses the pointer value at begin time.
- R8: 0x08 raises `mem_we` with `mem_addr` equal to the pointer and `mem_wdata` equal to the latch. Both stay constant until the 8th falling edge of the next accepted command. At that edge the write ends and that command executes.
- R9: Serial edges are ignored for PROG_MIN cycles after the begin-programming command, so a write lasts at least PROG_MIN cycles.
- R10: Serial edges are ignored for WR_GAP cycles before an incoming word, for RD_GAP cycles before an outgoing word, and for CMD_GAP cycles after any other command or word.
- R11: While `code_protect` is high, 0x08 leaves `mem_we` low and memory is unchanged.
- R12: Unlisted codes, and 0x0E when no write is in progress, change neither the pointer nor memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, one instruction cycle per period |
| rst | input | 1 | Synchronous active-high reset |
| code_protect | input | 1 | Blocks programming writes when high |
| ser_clk | input | 1 | Serial clock from programmer |
| ser_din | input | 1 | Serial data from programmer |
| ser_dout | output | 1 | Serial data to programmer |
| ser_oe | output | 1 | High while the device drives the data line |
| mem_addr | output | WORD_W | Memory address, equal to the pointer |
| mem_wdata | output | WORD_W | Memory write data, equal to the data latch |
| mem_we | output | 1 | Write strobe, high for the whole write cycle |
| mem_re | output | 1 | One-cycle read request |
| mem_rdata | input | WORD_W | Read data, valid the cycle after `mem_re` |

## Verification
Two functions fall in the same cycle: ending a write and executing the command that ends it. On the 8th falling edge of the following command, `mem_we` drops and the pointer is updated at the same clock edge. The bench provokes this by sending an increment right after a begin-programming command. It then reads the memory at the old address, which must hold the new word, and reads back the pointer, which must be one higher. A second case sends an increment inside the minimum write window and confirms that the increment is dropped and the strobe stays high.

// File: rtl/sp_pkg.sv
package sp_pkg;
  typedef enum logic [1:0] {
    ST_CMD  = 2'd0,
    ST_WIN  = 2'd1,
    ST_WOUT = 2'd2
  } sp_state_t;

  localparam logic [7:0] OP_PTR_CLR  = 8'h00;
  localparam logic [7:0] OP_LD_DATA  = 8'h02;
  localparam logic [7:0] OP_RD_DATA  = 8'h04;
  localparam logic [7:0] OP_PTR_INC  = 8'h06;
  localparam logic [7:0] OP_PROG_GO  = 8'h08;
  localparam logic [7:0] OP_LD_ADDR  = 8'h0A;
  localparam logic [7:0] OP_RD_ADDR  = 8'h0C;
  localparam logic [7:0] OP_PROG_END = 8'h0E;
endpackage

// File: rtl/sp_sync.sv
module sp_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= '0;
        else     chain[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= '0;
        else     chain[i] <= chain[i-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/sp_gap_timer.sv
module sp_gap_timer #(
  parameter int CW       = 8,
  parameter int INIT_VAL = 80
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          open
);
  localparam logic [CW-1:0] ONE = CW'(1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= CW'(INIT_VAL);
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - ONE;
  end

  assign open = (cnt == '0);

  // R10: an unloaded, nonzero window shrinks by exactly one per cycle
  assert_count_down_R10: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && !$past(load) && $past(cnt) != '0) |-> cnt == $past(cnt) - ONE);
endmodule

// File: rtl/sp_shreg.sv
module sp_shreg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift_en,
  input  logic         sin,
  output logic [W-1:0] q,
  output logic [W-1:0] nxt
);
  assign nxt = {sin, q[W-1:1]};

  always_ff @(posedge clk) begin
    if (rst)           q <= '0;
    else if (load)     q <= load_val;
    else if (shift_en) q <= nxt;
  end
endmodule

// File: rtl/sp_prog_engine.sv
module sp_prog_engine #(
  parameter int WORD_W      = 16,
  parameter int CMD_GAP     = 20,
  parameter int RD_GAP      = 20,
  parameter int WR_GAP      = 30,
  parameter int INIT_CYC    = 80,
  parameter int PROG_MIN    = 25000,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              code_protect,
  input  logic              ser_clk,
  input  logic              ser_din,
  output logic              ser_dout,
  output logic              ser_oe,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              mem_re,
  input  logic [WORD_W-1:0] mem_rdata
);
  import sp_pkg::*;

  localparam int M1   = (CMD_GAP > RD_GAP) ? CMD_GAP : RD_GAP;
  localparam int M2   = (M1 > WR_GAP) ? M1 : WR_GAP;
  localparam int M3   = (M2 > INIT_CYC) ? M2 : INIT_CYC;
  localparam int MAXV = (M3 > PROG_MIN) ? M3 : PROG_MIN;
  localparam int TW   = $clog2(MAXV + 1);
  localparam int CNTW = $clog2(WORD_W) + 1;

  sp_state_t         state;
  logic [WORD_W-1:0] ptr, dlatch;
  logic [CNTW-1:0]   bit_cnt;
  logic              rd_pend, wr_is_addr, sclk_d;
  logic [1:0]        sync_q;
  logic              sclk, sdin, open, rise, fall;
  logic              tmr_load;
  logic [TW-1:0]     tmr_val;
  logic              sh_load, sh_shift, sh_in;
  logic [WORD_W-1:0] sh_val, sh_q, sh_nxt;
  logic [7:0]        cmd;
  logic              cmd_last, word_last;

  sp_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d({ser_din, ser_clk}), .q(sync_q)
  );
  assign sclk = sync_q[0];
  assign sdin = sync_q[1];
  assign rise = sclk & ~sclk_d & open;
  assign fall = ~sclk & sclk_d & open;

  sp_gap_timer #(.CW(TW), .INIT_VAL(INIT_CYC)) u_gap (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .open(open)
  );

  sp_shreg #(.W(WORD_W)) u_sh (
    .clk(clk), .rst(rst), .load(sh_load), .load_val(sh_val),
    .shift_en(sh_shift), .sin(sh_in), .q(sh_q), .nxt(sh_nxt)
  );

  assign cmd       = sh_nxt[WORD_W-1 -: 8];
  assign cmd_last  = (bit_cnt == CNTW'(7));
  assign word_last = (bit_cnt == CNTW'(WORD_W - 1));
  assign mem_addr  = ptr;
  assign mem_wdata = dlatch;

  // control for timer and shifter
  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = TW'(CMD_GAP);
    sh_load  = 1'b0;
    sh_val   = ptr;
    sh_shift = 1'b0;
    sh_in    = sdin;
    case (state)
      ST_CMD: begin
        if (fall) begin
          sh_shift = 1'b1;
          if (cmd_last) begin
            tmr_load = 1'b1;
            case (cmd)
              OP_LD_DATA, OP_LD_ADDR: tmr_val = TW'(WR_GAP);
              OP_RD_DATA:             tmr_val = TW'(RD_GAP);
              OP_RD_ADDR: begin
                tmr_val = TW'(RD_GAP);
                sh_load = 1'b1;
              end
              OP_PROG_GO:             tmr_val = TW'(PROG_MIN);
              default:                tmr_val = TW'(CMD_GAP);
            endcase
          end
        end
      end
      ST_WIN: begin
        if (fall) begin
          sh_shift = 1'b1;
          if (word_last) tmr_load = 1'b1;
        end
      end
      ST_WOUT: begin
        if (rd_pend) begin
          sh_load = 1'b1;
          sh_val  = mem_rdata;
        end
        if (rise) begin
          sh_shift = 1'b1;
          sh_in    = 1'b0;
        end
        if (fall && word_last) tmr_load = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_CMD;
      ptr        <= '0;
      dlatch     <= '0;
      bit_cnt    <= '0;
      mem_we     <= 1'b0;
      mem_re     <= 1'b0;
      rd_pend    <= 1'b0;
      wr_is_addr <= 1'b0;
      sclk_d     <= 1'b0;
      ser_oe     <= 1'b0;
      ser_dout   <= 1'b0;
    end else begin
      sclk_d  <= sclk;
      mem_re  <= 1'b0;
      rd_pend <= mem_re;
      case (state)
        ST_CMD: begin
          if (fall) begin
            if (cmd_last) begin
              bit_cnt <= '0;
              mem_we  <= 1'b0;
              case (cmd)
                OP_PTR_CLR: ptr <= '0;
                OP_PTR_INC: ptr <= ptr + WORD_W'(1);
                OP_LD_DATA: begin
                  state      <= ST_WIN;
                  wr_is_addr <= 1'b0;
                end
                OP_LD_ADDR: begin
                  state      <= ST_WIN;
                  wr_is_addr <= 1'b1;
                end
                OP_RD_DATA: begin
                  state    <= ST_WOUT;
                  mem_re   <= 1'b1;
                  ser_oe   <= 1'b1;
                  ser_dout <= 1'b0;
                end
                OP_RD_ADDR: begin
                  state    <= ST_WOUT;
                  ser_oe   <= 1'b1;
                  ser_dout <= 1'b0;
                end
                OP_PROG_GO: mem_we <= ~code_protect;
                default: ;
              endcase
            end else begin
              bit_cnt <= bit_cnt + CNTW'(1);
            end
          end
        end
        ST_WIN: begin
          if (fall) begin
            if (word_last) begin
              bit_cnt <= '0;
              state   <= ST_CMD;
              if (wr_is_addr) ptr    <= sh_nxt;
              else            dlatch <= sh_nxt;
            end else begin
              bit_cnt <= bit_cnt + CNTW'(1);
            end
          end
        end
        ST_WOUT: begin
          if (rise) ser_dout <= sh_q[0];
          if (fall) begin
            if (word_last) begin
              bit_cnt <= '0;
              state   <= ST_CMD;
              ser_oe  <= 1'b0;
            end else begin
              bit_cnt <= bit_cnt + CNTW'(1);
            end
          end
        end
        default: state <= ST_CMD;
      endcase
    end
  end

  // checker-side length counter for the write strobe
  logic [TW-1:0] we_cyc;
  always_ff @(posedge clk) begin
    if (rst || !mem_we)     we_cyc <= '0;
    else if (we_cyc != '1)  we_cyc <= we_cyc + TW'(1);
  end

  assert_cp_blocks_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we) |-> !$past(code_protect));
  assert_we_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (mem_we && $past(mem_we)) |-> ($stable(mem_addr) && $stable(mem_wdata)));
  assert_we_min_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_we) |-> (int'(we_cyc) >= PROG_MIN));
  assert_oe_read_R6: assert property (@(posedge clk) disable iff (rst)
    ser_oe |-> (state == ST_WOUT));
  assert_rd_wr_excl_R8: assert property (@(posedge clk) disable iff (rst)
    !(mem_re && mem_we));
endmodule

// File: tb/tb_sp_prog_engine.sv
module tb_sp_prog_engine;
  localparam int PROG   = 300;
  localparam int HP     = 6;
  localparam int GAP    = 45;
  localparam int NVEC   = 26;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        code_protect = 1'b0;
  logic        ser_clk = 1'b0;
  logic        ser_din = 1'b0;
  logic        ser_dout, ser_oe, mem_we, mem_re;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic [15:0] mem [256];
  int          errors = 0;
  int          checks = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  sp_prog_engine #(.WORD_W(16), .PROG_MIN(PROG)) dut (
    .clk(clk), .rst(rst), .code_protect(code_protect),
    .ser_clk(ser_clk), .ser_din(ser_din), .ser_dout(ser_dout), .ser_oe(ser_oe),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .mem_re(mem_re), .mem_rdata(mem_rdata)
  );

  // behavioural program memory, 256 words, erased to all ones
  initial for (int i = 0; i < 256; i++) mem[i] = 16'hFFFF;
  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    if (mem_re) mem_rdata <= mem[mem_addr[7:0]];
  end

  // {command, argument, expected read value}
  localparam logic [39:0] VEC [NVEC] = '{
    {8'h0C, 16'h0000, 16'h0000},  // R1 pointer starts at zero
    {8'h0A, 16'h1234, 16'h0000},  // R4 load address
    {8'h0C, 16'h0000, 16'h1234},
    {8'h06, 16'h0000, 16'h0000},  // R5 increment
    {8'h0C, 16'h0000, 16'h1235},
    {8'h00, 16'h0000, 16'h0000},  // R5 clear
    {8'h0C, 16'h0000, 16'h0000},
    {8'h0A, 16'h0010, 16'h0000},
    {8'h02, 16'hA5C3, 16'h0000},  // R7 latch only
    {8'h04, 16'h0000, 16'hFFFF},
    {8'h0A, 16'h0020, 16'h0000},  // R7 pointer moves before programming
    {8'h08, 16'h0000, 16'h0000},  // R8 begin
    {8'h0E, 16'h0000, 16'h0000},
    {8'h04, 16'h0000, 16'hA5C3},
    {8'h0A, 16'h0010, 16'h0000},
    {8'h04, 16'h0000, 16'hFFFF},
    {8'h03, 16'h0000, 16'h0000},  // R12 unlisted code
    {8'h0C, 16'h0000, 16'h0010},
    {8'h0E, 16'h0000, 16'h0000},  // R12 end with no write
    {8'h0C, 16'h0000, 16'h0010},
    {8'h02, 16'h0F0F, 16'h0000},
    {8'h08, 16'h0000, 16'h0000},
    {8'h06, 16'h0000, 16'h0000},  // R8 ends write and increments together
    {8'h0C, 16'h0000, 16'h0011},
    {8'h0A, 16'h0010, 16'h0000},
    {8'h04, 16'h0000, 16'h0F0F}
  };

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send_bits(input logic [15:0] v, input int n);
    for (int i = 0; i < n; i++) begin
      ser_din = v[i];
      ser_clk = 1'b1;
      wait_cyc(HP);
      ser_clk = 1'b0;
      wait_cyc(HP);
    end
  endtask

  task automatic read_word(output logic [15:0] v, output bit oe_ok);
    oe_ok = 1'b1;
    v = '0;
    for (int i = 0; i < 16; i++) begin
      ser_clk = 1'b1;
      wait_cyc(HP);
      v[i] = ser_dout;
      if (!ser_oe) oe_ok = 1'b0;
      ser_clk = 1'b0;
      wait_cyc(HP);
    end
  endtask

  task automatic do_op(input logic [7:0] c, input logic [15:0] a, output logic [15:0] r, output bit oe_ok);
    r = '0;
    oe_ok = 1'b1;
    send_bits({8'h00, c}, 8);
    wait_cyc(GAP);
    if (c == 8'h02 || c == 8'h0A) begin
      send_bits(a, 16);
      wait_cyc(GAP);
    end else if (c == 8'h04 || c == 8'h0C) begin
      read_word(r, oe_ok);
      wait_cyc(GAP);
    end else if (c == 8'h08) begin
      wait_cyc(PROG);
    end
  endtask

  initial begin
    logic [15:0] r;
    bit oe_ok;
    wait_cyc(5);
    rst = 1'b0;
    wait_cyc(1);
    check(ser_oe == 1'b0, "R1 oe after reset", {15'd0, ser_oe}, 16'h0);
    check(mem_we == 1'b0, "R1 we after reset", {15'd0, mem_we}, 16'h0);
    // R2: stray pulse inside the init window must not shift a bit in
    wait_cyc(8);
    send_bits(16'h0001, 1);
    wait_cyc(100);

    for (int i = 0; i < NVEC; i++) begin
      logic [7:0]  c;
      logic [15:0] a, e;
      c = VEC[i][39:32];
      a = VEC[i][31:16];
      e = VEC[i][15:0];
      do_op(c, a, r, oe_ok);
      if (c == 8'h04 || c == 8'h0C) begin
        check(r == e, $sformatf("R3 table step %0d", i), r, e);
        check(oe_ok, $sformatf("R6 oe during read step %0d", i), {15'd0, oe_ok}, 16'h1);
        check(ser_oe == 1'b0, $sformatf("R6 oe after read step %0d", i), {15'd0, ser_oe}, 16'h0);
      end
    end

    // R5 wrap
    do_op(8'h0A, 16'hFFFF, r, oe_ok);
    do_op(8'h06, 16'h0000, r, oe_ok);
    do_op(8'h0C, 16'h0000, r, oe_ok);
    check(r == 16'h0000, "R5 wrap", r, 16'h0000);

    // R9 minimum write window swallows a command
    do_op(8'h0A, 16'h0030, r, oe_ok);
    do_op(8'h02, 16'h1111, r, oe_ok);
    send_bits(16'h0008, 8);
    wait_cyc(GAP);
    check(mem_we == 1'b1, "R8 strobe up", {15'd0, mem_we}, 16'h1);
    send_bits(16'h0006, 8);
    check(mem_we == 1'b1, "R9 strobe held in window", {15'd0, mem_we}, 16'h1);
    wait_cyc(PROG + GAP);
    check(mem_we == 1'b1, "R8 strobe waits for next command", {15'd0, mem_we}, 16'h1);
    do_op(8'h0E, 16'h0000, r, oe_ok);
    check(mem_we == 1'b0, "R8 strobe ends", {15'd0, mem_we}, 16'h0);
    do_op(8'h0C, 16'h0000, r, oe_ok);
    check(r == 16'h0030, "R9 increment ignored", r, 16'h0030);
    do_op(8'h04, 16'h0000, r, oe_ok);
    check(r == 16'h1111, "R8 word written", r, 16'h1111);

    // R11 code protection
    code_protect = 1'b1;
    do_op(8'h0A, 16'h0040, r, oe_ok);
    do_op(8'h02, 16'h2222, r, oe_ok);
    send_bits(16'h0008, 8);
    wait_cyc(GAP);
    check(mem_we == 1'b0, "R11 strobe blocked", {15'd0, mem_we}, 16'h0);
    wait_cyc(PROG);
    do_op(8'h0E, 16'h0000, r, oe_ok);
    do_op(8'h04, 16'h0000, r, oe_ok);
    check(r == 16'hFFFF, "R11 memory unchanged", r, 16'hFFFF);
    code_protect = 1'b0;

    // R10 early pulse before an incoming word is dropped
    send_bits(16'h000A, 8);
    wait_cyc(8);
    send_bits(16'h0001, 1);
    wait_cyc(GAP);
    send_bits(16'h0055, 16);
    wait_cyc(GAP);
    do_op(8'h0C, 16'h0000, r, oe_ok);
    check(r == 16'h0055, "R10 gap before word", r, 16'h0055);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule